// File: doc/BRIEF.md
# EDO DRAM Access and Refresh Sequencer

This block sits between an on-chip client and a x16 extended-data-out DRAM. The client offers word or byte requests on a valid/ready channel. Each request carries a word address, write data and two byte enables. The block turns each request into the row-strobe and column-strobe sequence the DRAM expects. The row part of the address goes out when the row strobe falls, and the column part goes out when the column strobe falls. Read data comes back as a one-cycle pulse on a separate output with no back-pressure. The client must be ready to take it.

When the next waiting request targets the row that is already open, the block keeps the row strobe low and issues only a new column cycle (page mode). It closes the row before the row-low budget would run out. A free-running interval counter asks for a column-before-row refresh. A pending refresh is served before any new row is opened, and it also stops an open page from being extended. Every timing limit is a parameter in clock cycles. The data bus is split into output, output-enable and input, so the pad ring can build the tri-state buffer.

Channel rules: a request transfers on a clock edge where `req_valid` and `req_ready` are both high. Once `req_valid` is raised, it and the request fields stay unchanged until that transfer. `req_ready` may depend on the offered address, because it only rises for a request to the open row while a page is open. A request to another row then waits until the row has been precharged.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is asserted, the row strobe, both column strobes, write enable and output enable are all high (inactive), the data driver is off and `rd_valid` is low.
- R2: The word address is split with the upper ROW_W bits as the row and the lower COL_W bits as the column. `dram_addr` carries the row on the cycle the row strobe falls for an access. It carries the column, with the upper bits zero, on the cycle a column strobe falls.
- R3: `dram_cas_n[0]` strobes the lower byte (data bits 7:0) and `dram_cas_n[1]` the upper byte (bits 15:8). For each lane, the strobe goes low during an access only if that byte-enable bit is set. A write changes only the enabled bytes. A read returns zero in disabled lanes.
- R4: In a write, write enable is low at least one cycle before the column strobe falls, and it stays low while the strobe is low. Write enable is never low while output enable is low.
- R5: Each accepted read produces exactly one single-cycle `rd_valid` pulse carrying the stored data, and the pulses come in request order.
- R6: A request to the open row that is waiting when column precharge ends is served in the same row cycle, with no new row-strobe fall, provided no refresh is pending and the row-low budget allows.
- R7: The row strobe never stays low for more than T_RAS_MAX consecutive cycles.
- R8: A refresh drives both column strobes low for at least T_CSR cycles before the row strobe falls, with write enable high. Refreshes recur at least once every REF_INTERVAL cycles plus the length of one in-progress access or page burst.
- R9: The data driver is never enabled while output enable is low. It is off in the cycle before output enable falls.
- R10: Between two row-strobe low periods, the row strobe stays high for at least T_RP cycles.
- R11: `req_ready` is high in idle when no refresh is pending. It is low while an access is in progress, except at the end of column precharge, for a request to the open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can transfer this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | 8*LANES | Write data |
| req_be | input | LANES | Byte enables, bit 0 = lower byte |
| rd_valid | output | 1 | Read data pulse |
| rd_data | output | 8*LANES | Read data, disabled lanes zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | LANES | Column strobe per byte lane, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | ROW_W | Multiplexed row/column address |
| dram_dq_out | output | 8*LANES | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for the data pads |
| dram_dq_in | input | 8*LANES | Data from the DRAM |

## Verification
The assertions check the pin-level ordering rules on every cycle. These are: quiet pins in reset, write enable settling before the column strobe falls, column-before-row order with write enable high at refresh, the row-low limit, precharge width, and the bus turnaround between driving and reading. The bench covers what needs a memory behind the pins. It shows that the row/column split and the byte lanes store and return the right data across the whole small array, and that reads come back in order. It also shows that page bursts open a row the computed number of times, and that refreshes keep recurring within their interval while traffic runs.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    S_IDLE,  // all strobes high, accept or refresh
    S_ROW,   // row strobe low, row address out
    S_CSET,  // column address and write enable set up, strobes high
    S_COL,   // column strobes low
    S_CPRE,  // column precharge, row kept open
    S_PRE,   // row precharge
    S_RFC,   // refresh: column strobes low first
    S_RFR    // refresh: row strobe low
  } edo_state_e;

  function automatic int edo_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 1950
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_ack,
  output logic ref_pending
);
  localparam int CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt         <= CW'(INTERVAL - 1);
      ref_pending <= 1'b0;
    end else if (cnt == '0) begin
      // a new tick keeps the request alive even if one is acked now
      cnt         <= CW'(INTERVAL - 1);
      ref_pending <= 1'b1;
    end else begin
      cnt <= cnt - 1'b1;
      if (ref_ack) ref_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 10,
  parameter int LANES     = 2,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 2,
  parameter int T_CP      = 2,
  parameter int T_RP      = 4,
  parameter int T_CSR     = 2,
  parameter int T_RFR     = 6,
  parameter int T_RAS_MAX = 10000,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int DATA_W   = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  input  logic              ref_pending,
  output logic              ref_ack,
  output edo_state_e        state,
  output logic              col_last,
  output logic [ROW_W-1:0]  lat_row,
  output logic [COL_W-1:0]  lat_col,
  output logic [LANES-1:0]  lat_be,
  output logic              lat_wr,
  output logic [DATA_W-1:0] lat_wdata
);
  localparam int TMAX = edo_max(edo_max(edo_max(T_RCD, T_CAS), edo_max(T_CP, T_RP)),
                                edo_max(T_CSR, T_RFR));
  localparam int TW   = $clog2(TMAX + 1);
  localparam int RW   = $clog2(T_RAS_MAX + 1) + 1;
  // row-low cycles one more page column adds (setup + strobe + precharge)
  localparam int COLUMN_COST = 1 + T_CAS + T_CP;

  edo_state_e    nxt;
  logic [TW-1:0] tmr, tmr_load;
  logic          tmr_zero;
  logic [RW-1:0] ras_cnt;
  logic          same_row, budget_ok, acc;
  logic          low_now, low_next;

  assign tmr_zero  = (tmr == '0);
  assign same_row  = (req_addr[ADDR_W-1:COL_W] == lat_row);
  assign budget_ok = (32'(ras_cnt) + 32'(COLUMN_COST) + 32'd1) <= 32'(T_RAS_MAX);
  assign acc       = req_valid && req_ready;
  assign col_last  = (state == S_COL) && tmr_zero;

  always_comb begin
    nxt       = state;
    tmr_load  = '0;
    req_ready = 1'b0;
    ref_ack   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (ref_pending) begin
          nxt      = S_RFC;
          tmr_load = TW'(T_CSR - 1);
          ref_ack  = 1'b1;
        end else begin
          req_ready = 1'b1;
          if (req_valid) begin
            nxt      = S_ROW;
            tmr_load = TW'(T_RCD - 1);
          end
        end
      end
      S_ROW:  if (tmr_zero) nxt = S_CSET;
      S_CSET: begin
        nxt      = S_COL;
        tmr_load = TW'(T_CAS - 1);
      end
      S_COL: if (tmr_zero) begin
        nxt      = S_CPRE;
        tmr_load = TW'(T_CP - 1);
      end
      S_CPRE: if (tmr_zero) begin
        req_ready = !ref_pending && same_row && budget_ok;
        if (req_ready && req_valid) begin
          nxt = S_CSET;
        end else begin
          nxt      = S_PRE;
          tmr_load = TW'(T_RP - 1);
        end
      end
      S_PRE: if (tmr_zero) nxt = S_IDLE;
      S_RFC: if (tmr_zero) begin
        nxt      = S_RFR;
        tmr_load = TW'(T_RFR - 1);
      end
      S_RFR: if (tmr_zero) begin
        nxt      = S_PRE;
        tmr_load = TW'(T_RP - 1);
      end
      default: nxt = S_IDLE;
    endcase
  end

  assign low_now  = (state == S_ROW) || (state == S_CSET) || (state == S_COL) || (state == S_CPRE);
  assign low_next = (nxt == S_ROW) || (nxt == S_CSET) || (nxt == S_COL) || (nxt == S_CPRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      tmr     <= '0;
      ras_cnt <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)   tmr <= tmr_load;
      else if (!tmr_zero) tmr <= tmr - 1'b1;
      ras_cnt <= (low_now && low_next) ? ras_cnt + 1'b1 : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_row   <= '0;
      lat_col   <= '0;
      lat_be    <= '0;
      lat_wr    <= 1'b0;
      lat_wdata <= '0;
    end else if (acc) begin
      lat_row   <= req_addr[ADDR_W-1:COL_W];
      lat_col   <= req_addr[COL_W-1:0];
      lat_be    <= req_be;
      lat_wr    <= req_write;
      lat_wdata <= req_wdata;
    end
  end
endmodule

// File: rtl/edo_pins.sv
module edo_pins
  import edo_pkg::*;
#(
  parameter int ROW_W   = 12,
  parameter int COL_W   = 10,
  parameter int LANES   = 2,
  localparam int DATA_W = 8 * LANES
) (
  input  edo_state_e        state,
  input  logic [ROW_W-1:0]  lat_row,
  input  logic [COL_W-1:0]  lat_col,
  input  logic [LANES-1:0]  lat_be,
  input  logic              lat_wr,
  input  logic [DATA_W-1:0] lat_wdata,
  output logic              ras_n,
  output logic [LANES-1:0]  cas_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [ROW_W-1:0]  addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);
  logic col_phase, refresh_cas, data_phase;

  assign col_phase   = (state == S_CSET) || (state == S_COL) || (state == S_CPRE);
  assign refresh_cas = (state == S_RFC) || (state == S_RFR);
  assign data_phase  = (state == S_CSET) || (state == S_COL);

  assign ras_n = !((state == S_ROW) || col_phase || (state == S_RFR));
  assign we_n  = !(lat_wr && data_phase);
  assign oe_n  = !(!lat_wr && (state == S_COL));
  assign dq_oe = lat_wr && data_phase;
  assign addr  = col_phase ? {{(ROW_W - COL_W){1'b0}}, lat_col} : lat_row;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign cas_n[g]        = !(((state == S_COL) && lat_be[g]) || refresh_cas);
    assign dq_out[8*g +: 8] = lat_wdata[8*g +: 8];
  end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 12,
  parameter int COL_W        = 10,
  parameter int LANES        = 2,
  parameter int T_RCD        = 3,
  parameter int T_CAS        = 2,
  parameter int T_CP         = 2,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 2,
  parameter int T_RFR        = 6,
  parameter int T_RAS_MAX    = 10000,
  parameter int REF_INTERVAL = 1950,
  localparam int ADDR_W      = ROW_W + COL_W,
  localparam int DATA_W      = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_be,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              dram_ras_n,
  output logic [LANES-1:0]  dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [ROW_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);
  edo_state_e        state;
  logic              ref_pending, ref_ack, col_last, lat_wr;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [LANES-1:0]  lat_be;
  logic [DATA_W-1:0] lat_wdata, lane_mask;

  edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_ack(ref_ack), .ref_pending(ref_pending)
  );

  edo_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFR(T_RFR), .T_RAS_MAX(T_RAS_MAX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .ref_pending(ref_pending), .ref_ack(ref_ack), .state(state), .col_last(col_last),
    .lat_row(lat_row), .lat_col(lat_col), .lat_be(lat_be), .lat_wr(lat_wr),
    .lat_wdata(lat_wdata)
  );

  edo_pins #(.ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES)) u_pins (
    .state(state), .lat_row(lat_row), .lat_col(lat_col), .lat_be(lat_be),
    .lat_wr(lat_wr), .lat_wdata(lat_wdata), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
    .we_n(dram_we_n), .oe_n(dram_oe_n), .addr(dram_addr), .dq_out(dram_dq_out),
    .dq_oe(dram_dq_oe)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_mask
    assign lane_mask[8*g +: 8] = {8{lat_be[g]}};
  end

  // read data sampled on the last strobe-low cycle, returned next cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= col_last && !lat_wr;
      if (col_last && !lat_wr) rd_data <= dram_dq_in & lane_mask;
    end
  end
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int LANES     = 2,
  parameter int T_RP      = 4,
  parameter int T_RAS_MAX = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic [LANES-1:0] cas_n,
  input logic             we_n,
  input logic             oe_n,
  input logic             dq_oe,
  input logic             rd_valid
);
  localparam int LW = $clog2(T_RAS_MAX + 1) + 1;
  localparam int HW = $clog2(T_RP + 1) + 1;

  logic [LW-1:0] low_cnt;
  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= HW'(T_RP);
    end else if (ras_n) begin
      low_cnt  <= '0;
      if (high_cnt < HW'(T_RP)) high_cnt <= high_cnt + 1'b1;
    end else begin
      high_cnt <= '0;
      if (low_cnt <= LW'(T_RAS_MAX)) low_cnt <= low_cnt + 1'b1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |-> (ras_n && (&cas_n) && we_n && oe_n && !dq_oe && !rd_valid)); // R1
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(&cas_n) && !we_n) |-> !$past(we_n)); // R4
  AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> we_n); // R4
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R5
  AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (low_cnt < LW'(T_RAS_MAX))); // R7
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !(&cas_n)) |-> ($past(~|cas_n) && we_n)); // R8
  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe); // R9
  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(dq_oe)); // R9
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> (high_cnt >= HW'(T_RP))); // R10
endmodule

bind edo_ctrl edo_ctrl_chk #(.LANES(LANES), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n), .we_n(dram_we_n),
  .oe_n(dram_oe_n), .dq_oe(dram_dq_oe), .rd_valid(rd_valid)
);

// File: tb/edo_ctrl_tb_top.sv
module edo_ctrl_tb_top;
  localparam int ROW_W = 4, COL_W = 3, LANES = 2;
  localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 2, T_CSR = 1, T_RFR = 3;
  localparam int T_RAS_MAX = 24, REF_INTERVAL = 150;
  localparam int WORDS = 1 << (ROW_W + COL_W);
  localparam int FIRST_COST = T_RCD + 1 + T_CAS + T_CP;
  localparam int COL_COST = 1 + T_CAS + T_CP;
  localparam int PER_OPEN = 1 + (T_RAS_MAX - FIRST_COST) / COL_COST;
  localparam int REF_SLACK = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [6:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_be = '0;
  logic req_ready, rd_valid, ras_n, we_n, oe_n, dq_oe;
  logic [15:0] rd_data, dq_out, dq_in;
  logic [1:0] cas_n;
  logic [3:0] daddr;

  int checks = 0, fails = 0;
  logic [15:0] mem [0:WORDS-1];
  logic [15:0] exp_mem [0:WORDS-1];
  logic [15:0] exp_rd [0:1023];
  logic [15:0] rd_log [0:1023];
  int n_exp = 0, n_rd = 0;
  logic [3:0] m_row = '0;
  bit is_ref = 0, prev_ras_n = 1, prev_cas_high = 1, prev_we_n = 1, prev_dq_oe = 0;
  int low_run = 0, high_run = 100, cas_pre_run = 0, max_low = 0, min_high = 1000;
  int falls_acc = 0, refs = 0, last_ref = 0, max_gap = 0, cyc = 0;
  int v_we = 0, v_bus = 0, v_cbr = 0, v_addr = 0;

  always #4 clk = ~clk;

  edo_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANES(LANES), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_CP(T_CP), .T_RP(T_RP), .T_CSR(T_CSR), .T_RFR(T_RFR), .T_RAS_MAX(T_RAS_MAX),
    .REF_INTERVAL(REF_INTERVAL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_ras_n(ras_n), .dram_cas_n(cas_n),
    .dram_we_n(we_n), .dram_oe_n(oe_n), .dram_addr(daddr), .dram_dq_out(dq_out),
    .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  // memory model: data only while row open and output enabled
  assign dq_in = (!ras_n && !oe_n) ? mem[{m_row, daddr[2:0]}] : 16'hA5A5;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mask(input logic [1:0] be);
    return {{8{be[1]}}, {8{be[0]}}};
  endfunction

  // pin monitor and memory model, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rd_valid) begin rd_log[n_rd] = rd_data; n_rd++; end
      if (prev_ras_n && !ras_n) begin
        if (high_run < min_high) min_high = high_run;
        if (&cas_n) begin
          falls_acc++; m_row = daddr; is_ref = 0;
        end else begin
          is_ref = 1; refs++;
          if (cas_pre_run < T_CSR || !we_n || cas_n != 2'b00) v_cbr++;
          if (refs > 1 && cyc - last_ref > max_gap) max_gap = cyc - last_ref;
          last_ref = cyc;
        end
      end
      if (!ras_n && !is_ref) begin
        if (prev_cas_high && !(&cas_n)) begin
          if (daddr[3] != 1'b0) v_addr++;
          if (!we_n && prev_we_n) v_we++;
        end
        if (!we_n) begin
          if (!cas_n[0]) mem[{m_row, daddr[2:0]}][7:0]  = dq_out[7:0];
          if (!cas_n[1]) mem[{m_row, daddr[2:0]}][15:8] = dq_out[15:8];
        end
      end
      if (!oe_n && !we_n) v_we++;
      if (!oe_n && (dq_oe || prev_dq_oe)) v_bus++;
      if (ras_n) begin
        high_run++; low_run = 0;
        cas_pre_run = (cas_n == 2'b00) ? cas_pre_run + 1 : 0;
      end else begin
        low_run++; high_run = 0;
        if (low_run > max_low) max_low = low_run;
      end
      prev_ras_n = ras_n; prev_cas_high = &cas_n; prev_we_n = we_n; prev_dq_oe = dq_oe;
    end
  end

  task automatic send(input bit wr, input int a, input logic [15:0] d, input logic [1:0] be);
    req_valid = 1'b1; req_write = wr; req_addr = a[6:0]; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (wr) exp_mem[a] = (exp_mem[a] & ~mask(be)) | (d & mask(be));
    else begin exp_rd[n_exp] = exp_mem[a] & mask(be); n_exp++; end
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  task automatic wait_refresh();
    int r = refs;
    while (refs == r) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_reads(input int from, input string req);
    for (int i = from; i < n_exp; i++)
      chk(rd_log[i] == exp_rd[i], req, rd_log[i], exp_rd[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0, base;
    for (int i = 0; i < WORDS; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet pins in reset
    chk(ras_n && cas_n == 2'b11 && we_n && oe_n && !dq_oe && !rd_valid, "R1 reset pins",
        {ras_n, cas_n, we_n, oe_n, dq_oe, rd_valid}, 7'b1111100);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(req_ready, "R11 ready in idle", req_ready, 1);

    // R2 / R5: full word sweep
    for (int a = 0; a < WORDS; a++) send(1, a, 16'((a * 16'h3B1 + 16'h1234) ^ (a << 9)), 2'b11);
    settle();
    for (int a = 0; a < WORDS; a++) chk(mem[a] == exp_mem[a], "R2 stored at row/col", mem[a], exp_mem[a]);
    base = n_exp;
    for (int a = 0; a < WORDS; a++) send(0, a, 16'h0, 2'b11);
    settle();
    cmp_reads(base, "R5 read data");
    chk(n_rd == n_exp, "R5 pulse count", n_rd, n_exp);

    // R3: byte lanes
    base = n_exp;
    for (int a = 0; a < WORDS; a += 9) begin
      send(1, a, 16'hC300 | 16'(a), 2'b01);
      send(1, a, 16'h005A | 16'(a << 8), 2'b10);
      send(0, a, 16'h0, 2'b11);
      send(0, a, 16'h0, 2'b01);
      send(0, a, 16'h0, 2'b10);
    end
    settle();
    cmp_reads(base, "R3 byte lanes");

    // R11: ready low during an access for another row
    send(1, 20, 16'hBEEF, 2'b11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 7'd100; req_wdata = 16'h1357; req_be = 2'b11;
    #1;
    chk(!req_ready, "R11 ready low while busy", req_ready, 0);
    @(negedge clk);
    send(1, 100, 16'h1357, 2'b11);
    settle();

    // R6: short page burst opens the row once
    wait_refresh();
    f0 = falls_acc;
    for (int c = 0; c < 3; c++) send(1, 5 * 8 + c, 16'h7000 + 16'(c), 2'b11);
    settle();
    chk(falls_acc - f0 == 1, "R6 page burst row opens", falls_acc - f0, 1);

    // R7: long burst is split by the row-low budget
    wait_refresh();
    f0 = falls_acc;
    for (int c = 0; c < 12; c++) send(1, 9 * 8 + (c % 8), 16'h9000 + 16'(c), 2'b11);
    settle();
    chk(falls_acc - f0 == (12 + PER_OPEN - 1) / PER_OPEN, "R7 burst splits",
        falls_acc - f0, (12 + PER_OPEN - 1) / PER_OPEN);
    chk(max_low <= T_RAS_MAX, "R7 row low limit", max_low, T_RAS_MAX);

    base = n_exp;
    for (int a = 0; a < WORDS; a += 3) send(0, a, 16'h0, 2'b11);
    settle();
    cmp_reads(base, "R6 data after bursts");

    // monitor-based results
    chk(v_addr == 0, "R2 column upper bits", v_addr, 0);
    chk(v_we == 0, "R4 write enable order", v_we, 0);
    chk(v_cbr == 0, "R8 refresh strobe order", v_cbr, 0);
    chk(refs >= cyc / REF_INTERVAL - 1, "R8 refresh count", refs, cyc / REF_INTERVAL - 1);
    chk(max_gap <= REF_INTERVAL + REF_SLACK, "R8 refresh gap", max_gap, REF_INTERVAL + REF_SLACK);
    chk(v_bus == 0, "R9 bus turnaround", v_bus, 0);
    chk(min_high >= T_RP, "R10 precharge width", min_high, T_RP);
    chk(n_rd == n_exp, "R5 total pulses", n_rd, n_exp);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule